// File: doc/BRIEF.md
# Alarm-Driven Gate Clamp Controller

This block decides, for one bias channel, whether the gate drive is pulled to ground. A host programs a 2-bit clamp policy through a write port. Each finished current or temperature conversion arrives as a one-cycle strobe with a flag that says whether that sample breached its limit. The block keeps a sticky alarm flag and drives a registered clamp request to the analog gate driver. It also shows the policy field as it stands, because one policy rewrites that field by itself.

There are four policies. Code 00 only reports alarms. Code 01 clamps the gate without condition. Code 10 clamps on an alarm and releases the clamp on the next clean conversion. Code 11 clamps on an alarm and then turns itself into code 01. That clamp stays on until the host writes 11 again. A system with two channels uses two instances. The converter, the limit comparison and the gate driver are outside this block.

Top module: `gate_clamp_ctrl`

## Requirements
- R1: After reset the policy readback is 00, the clamp output is 0 and the alarm flag is 0.
- R2: A host write (`cfg_wr_en`=1) loads `cfg_wr_mode` into the policy field, and `mode_rd` shows it after the next clock edge.
- R3: With policy 00 (report only), a trip (`conv_done`=1 with `conv_alarm`=1) sets the alarm flag and the clamp stays 0.
- R4: With policy 01 (force), the clamp is 1 from the edge that loads the policy onward, whatever conversions arrive.
- R5: With policy 10 (auto-release), a trip sets the clamp at the clock edge that samples the strobe.
- R6: With policy 10 and the clamp set, a clean conversion (`conv_done`=1, `conv_alarm`=0) clears the clamp at that edge. `conv_alarm` is ignored while `conv_done` is 0.
- R7: With policy 11 (latching), a trip sets the clamp and rewrites the policy field to 01 at the same edge.
- R8: A latched clamp is not released by clean conversions. A host write of 11 releases it at the next edge.
- R9: A trip sets the alarm flag under every policy. The flag then holds until `alarm_clr` is pulsed, and a trip in the same cycle as the clear wins.
- R10: When a host write and a trip under policy 11 fall in the same cycle, the written value is the one loaded.
- R11: Loading any policy other than 10 discards the auto-release clamp state. A later write of 10 starts with the clamp off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Host write strobe for the policy field |
| cfg_wr_mode | input | 2 | Policy value to write |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_alarm | input | 1 | Limit breach flag for the conversion, valid with `conv_done` |
| alarm_clr | input | 1 | Host clear strobe for the alarm flag |
| clamp | output | 1 | Registered request to ground the gate |
| alarm_flag | output | 1 | Sticky alarm flag |
| mode_rd | output | 2 | Current policy field |

## Verification
The assertions assume the inputs are settled 0/1 values once reset is released. They also assume `conv_alarm` matters only in cycles where `conv_done` is high. Apart from that, any combination is legal, including a host write, a trip and a clear in the same cycle. The bench keeps to these rules by driving every input at the falling edge. It draws random mixes in which writes, strobes, alarm values and clears coincide often, so the priority cases come up many times.

// File: rtl/gcc_pkg.sv
// Package: shared policy encoding for the gate clamp controller.
// Assumes a 2-bit policy field whose codes are fixed by the host interface.
package gcc_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        POL_REPORT = 2'b00,
        POL_FORCE  = 2'b01,
        POL_AUTO   = 2'b10,
        POL_LATCH  = 2'b11
    } policy_t;

endpackage

// File: rtl/gcc_mode_reg.sv
// Module: policy field register.
// Holds the clamp policy. A host write has priority over the self-rewrite
// from latching policy to force policy on a trip. It also exports the
// next-state value so the clamp stage can register a matching clamp in the
// same cycle. Assumes trip is already qualified by the conversion strobe.
module gcc_mode_reg
    import gcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  policy_t wr_val,
    input  logic    trip,
    output policy_t pol_q,
    output policy_t pol_d
);

    // Next policy: host write first, then the latching rewrite.
    always_comb begin
        pol_d = pol_q;
        if (wr_en) begin
            pol_d = wr_val;
        end else if (pol_q == POL_LATCH && trip) begin
            pol_d = POL_FORCE;
        end
    end

    // Policy storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= POL_REPORT;
        end else begin
            pol_q <= pol_d;
        end
    end

endmodule

// File: rtl/gcc_alarm_flag.sv
// Module: sticky alarm flag.
// Set by a trip under any policy and cleared by the host strobe. A set in
// the same cycle as a clear wins. Assumes trip is strobe-qualified.
module gcc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr,
    output logic flag_q
);

    // Sticky flag update; set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (trip) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/gcc_clamp_core.sv
// Module: clamp decision stage.
// Computes the registered clamp from the next policy value. The force policy
// clamps without condition. The auto-release policy keeps a hold bit that a
// trip sets and a clean conversion clears. The hold bit is dropped whenever
// the next policy is not auto-release. Assumes trip and clean never occur
// together, since both come from one strobe.
module gcc_clamp_core
    import gcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  policy_t pol_d,
    input  logic    trip,
    input  logic    clean,
    output logic    clamp_q
);

    logic hold_q;
    logic hold_d;
    logic clamp_d;

    // Next hold and clamp values from the next policy and this cycle's events.
    always_comb begin
        hold_d  = (pol_d == POL_AUTO) && (trip || (hold_q && !clean));
        clamp_d = (pol_d == POL_FORCE) || hold_d;
    end

    // Hold and clamp registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            clamp_q <= 1'b0;
        end else begin
            hold_q  <= hold_d;
            clamp_q <= clamp_d;
        end
    end

endmodule

// File: rtl/gate_clamp_ctrl.sv
// Module: per-channel gate clamp controller (top).
// Qualifies the conversion result with its strobe and joins the policy
// register, the sticky alarm flag and the clamp stage. Assumes conv_alarm
// has meaning only while conv_done is high.
module gate_clamp_ctrl
    import gcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [MODE_W-1:0] cfg_wr_mode,
    input  logic              conv_done,
    input  logic              conv_alarm,
    input  logic              alarm_clr,
    output logic              clamp,
    output logic              alarm_flag,
    output logic [MODE_W-1:0] mode_rd
);

    logic    trip;
    logic    clean;
    policy_t pol_q;
    policy_t pol_d;

    // Strobe-qualified conversion outcomes.
    always_comb begin
        trip  = conv_done && conv_alarm;
        clean = conv_done && !conv_alarm;
    end

    gcc_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .wr_val (policy_t'(cfg_wr_mode)),
        .trip   (trip),
        .pol_q  (pol_q),
        .pol_d  (pol_d)
    );

    gcc_alarm_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip   (trip),
        .clr    (alarm_clr),
        .flag_q (alarm_flag)
    );

    gcc_clamp_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pol_d   (pol_d),
        .trip    (trip),
        .clean   (clean),
        .clamp_q (clamp)
    );

    assign mode_rd = pol_q;

endmodule

// File: rtl/gcc_checker.sv
// Module: port-level property checker for gate_clamp_ctrl, attached by bind.
// Assumes inputs hold known values while reset is released.
module gcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr_en,
    input logic [1:0] cfg_wr_mode,
    input logic       conv_done,
    input logic       conv_alarm,
    input logic       alarm_clr,
    input logic       clamp,
    input logic       alarm_flag,
    input logic [1:0] mode_rd
);

    // R3
    report_no_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp |-> (mode_rd == 2'b01 || mode_rd == 2'b10));

    // R4
    force_clamps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b01) |-> clamp);

    // R5
    auto_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b10 && !cfg_wr_en && conv_done && conv_alarm) |=> clamp);

    // R6
    auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b10 && !cfg_wr_en && conv_done && !conv_alarm) |=> !clamp);

    // R7
    latch_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 2'b11 && !cfg_wr_en && conv_done && conv_alarm)
        |=> (mode_rd == 2'b01 && clamp));

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_alarm) |=> alarm_flag);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !alarm_clr) |=> alarm_flag);

    // R10
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (mode_rd == $past(cfg_wr_mode)));

endmodule

bind gate_clamp_ctrl gcc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_mode (cfg_wr_mode),
    .conv_done   (conv_done),
    .conv_alarm  (conv_alarm),
    .alarm_clr   (alarm_clr),
    .clamp       (clamp),
    .alarm_flag  (alarm_flag),
    .mode_rd     (mode_rd)
);

// File: tb/sim_gate_clamp_ctrl.sv
// Bench: directed corner cases, then fixed-seed random traffic, all checked
// against a reference model written from the requirements.
module sim_gate_clamp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_mode = 2'b00;
    logic       conv_done = 1'b0;
    logic       conv_alarm = 1'b0;
    logic       alarm_clr = 1'b0;
    logic       clamp;
    logic       alarm_flag;
    logic [1:0] mode_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state
    logic [1:0] e_mode;
    logic       e_hold;
    logic       e_clamp;
    logic       e_flag;

    always #2 clk = ~clk;

    gate_clamp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_mode(cfg_wr_mode),
        .conv_done(conv_done), .conv_alarm(conv_alarm), .alarm_clr(alarm_clr),
        .clamp(clamp), .alarm_flag(alarm_flag), .mode_rd(mode_rd)
    );

    function automatic logic [1:0] next_mode(logic [1:0] m, logic we, logic [1:0] wv, logic tr);
        if (we) return wv;
        if (m == 2'b11 && tr) return 2'b01;
        return m;
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model, compare after rising edge.
    task automatic step(logic we, logic [1:0] wv, logic dn, logic al, logic cl,
                        string tm, string tc, string tf);
        logic tr;
        logic cn;
        logic [1:0] nm;
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_mode = wv; conv_done = dn; conv_alarm = al; alarm_clr = cl;
        tr = dn && al;
        cn = dn && !al;
        nm = next_mode(e_mode, we, wv, tr);
        e_hold  = (nm == 2'b10) && (tr || (e_hold && !cn));
        e_clamp = (nm == 2'b01) || e_hold;
        e_flag  = tr ? 1'b1 : (cl ? 1'b0 : e_flag);
        e_mode  = nm;
        @(posedge clk);
        #1;
        check(tm, mode_rd, e_mode);
        check(tc, {1'b0, clamp}, {1'b0, e_clamp});
        check(tf, {1'b0, alarm_flag}, {1'b0, e_flag});
    endtask

    task automatic wr(logic [1:0] v, string t);
        step(1'b1, v, 1'b0, 1'b0, 1'b0, t, t, t);
    endtask

    task automatic conv(logic al, string t);
        step(1'b0, 2'b00, 1'b1, al, 1'b0, t, t, t);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd24681));
        e_mode = 2'b00; e_hold = 1'b0; e_clamp = 1'b0; e_flag = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", mode_rd, 2'b00);
        check("R1", {1'b0, clamp}, 2'b00);
        check("R1", {1'b0, alarm_flag}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 readback follows a write
        wr(2'b10, "R2");
        wr(2'b00, "R2");
        // R3 report-only: flag set, no clamp
        conv(1'b1, "R3");
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, "R9", "R9", "R9");
        // R4 force policy clamps regardless
        wr(2'b01, "R4");
        conv(1'b0, "R4");
        conv(1'b1, "R4");
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, "R4", "R4", "R9");
        // R5/R6 auto-release
        wr(2'b10, "R5");
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, "R6", "R6", "R6");
        conv(1'b1, "R5");
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "R5", "R5", "R5");
        conv(1'b0, "R6");
        // R7 latching rewrite, R8 permanent clamp
        wr(2'b11, "R7");
        conv(1'b1, "R7");
        conv(1'b0, "R8");
        conv(1'b0, "R8");
        wr(2'b11, "R8");
        // R9 set beats clear
        step(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, "R9", "R9", "R9");
        wr(2'b11, "R9");
        // R10 host write beats rewrite
        step(1'b1, 2'b10, 1'b1, 1'b1, 1'b0, "R10", "R10", "R10");
        // R11 leaving auto-release drops the hold
        wr(2'b00, "R11");
        wr(2'b10, "R11");
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "R11", "R11", "R11");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic dn;
            logic al;
            logic cl;
            logic [1:0] wv;
            we = ($urandom % 6) == 0;
            wv = 2'($urandom);
            dn = ($urandom % 3) == 0;
            al = $urandom;
            cl = ($urandom % 5) == 0;
            step(we, wv, dn, al, cl, "R10", "R5", "R9");
        end
        summary();
    end

endmodule